// File: doc/BRIEF.md
# Track Cutout Window Timer

This block produces the bit-time heartbeat for a model-railway track signal and a control output that opens a quiet window on the track after each packet. A free-running counter divides the system clock into a base tick every 58 microseconds; a one-cycle strobe marks each tick so the packet encoder can step its bit stream.

When the encoder signals the end of a packet with a start pulse, the block arms itself. The cutout output rises at a fixed 28-microsecond offset after a base tick, so the window is phase-locked to the bit grid and not to when the request arrived. A second, slower timer with a 436-microsecond period then runs from that rising point. The output stays high across that timer's ticks until a clear pulse arrives, and it drops only at the next tick of the slow timer. This gives the window a quantised, predictable length, whatever the software latency of the clear.

All intervals are given in microseconds and turned into clock counts when the design is built, from a clock-frequency parameter that defaults to 16 MHz. The frequency must be a whole number of MHz. The offset must come to between 2 cycles and one base period. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `cutout_window_timer`

## Requirements
- R1: `base_tick_o` is a one-cycle pulse that repeats every BASE_US × CLK_HZ/1e6 clock cycles.
- R2: While `rst_ni` is low, `base_tick_o`, `cutout_o` and `window_o` are low. A reset asserted during an open window drops `cutout_o` and `window_o` at once, without waiting for a clock edge.
- R3: A start pulse in a cycle when `window_o` is low raises `window_o` in the next cycle. `cutout_o` stays low until the phase point given in R4.
- R4: `cutout_o` first reads high in the earliest cycle that is exactly OFFSET_US × CLK_HZ/1e6 cycles after a `base_tick_o` cycle and is later than the start cycle.
- R5: With no clear pulse, `cutout_o` stays high through every tick of the cutout timer. Those ticks fall every CUT_US × CLK_HZ/1e6 cycles, counted from the cycle in which `cutout_o` rose.
- R6: A clear pulse in any cycle where `cutout_o` is high makes `cutout_o` and `window_o` go low together. They fall in the first cycle of the form rise + k × CUT cycles (k ≥ 1) that is later than the clear cycle.
- R7: A start pulse while `window_o` is high has no effect on when the window opens or closes.
- R8: A clear pulse while `cutout_o` is low, whether idle or armed, has no effect. The window opens as in R4 and is not shortened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req_i | input | 1 | One-cycle request to open a cutout window |
| clear_req_i | input | 1 | One-cycle request to end the open window |
| base_tick_o | output | 1 | Base bit-time strobe, one cycle wide |
| cutout_o | output | 1 | Cutout control, high while the quiet window is open |
| window_o | output | 1 | High from an accepted start until the cutout output falls |

## Verification
The bench scales the clock to 1 MHz so that one cycle is one microsecond. It then issues a start at every one of the 58 possible phases relative to the last base tick. These phases separate a start just before the offset point, which opens the window in the next cycle, from a start just after it, which has to wait almost a full base period. The clear delay changes from run to run. Runs with a clear in the same cycle as the rise, in the last cycle before the first cutout-timer tick, and exactly on that tick tell apart a design that drops the output at once, one that ends at the first tick, and one that correctly holds until the following tick. Every run also pulses start and clear where both must be ignored. One run ends with a reset in the middle of a window.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    CW_IDLE  = 2'b00,
    CW_ARMED = 2'b01,
    CW_OPEN  = 2'b11
  } cw_state_e;

  // Clock cycles in a span of microseconds at a whole-MHz clock.
  function automatic int us_to_cyc(input int clk_hz, input int span_us);
    return (clk_hz / 1_000_000) * span_us;
  endfunction

endpackage

// File: rtl/cw_base_tick.sv
module cw_base_tick #(
  parameter int PERIOD   = 928,
  parameter int MATCH_AT = 446
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic match_o
);

  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST  = W'(PERIOD - 1);
  localparam logic [W-1:0] MATCH = W'(MATCH_AT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o  = (cnt_q == LAST);
  assign match_o = (cnt_q == MATCH);

  // R1
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R1
  tick_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> !match_o);

endmodule

// File: rtl/cw_window_timer.sv
module cw_window_timer #(
  parameter int PERIOD = 6976
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = run_i & wrap;

  // R5
  timer_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !tick_o);

endmodule

// File: rtl/cw_window_fsm.sv
module cw_window_fsm
  import cw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  input  logic phase_i,
  input  logic cut_tick_i,
  output logic run_o,
  output logic cut_o,
  output logic active_o
);

  cw_state_e state_q, state_d;
  logic      pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CW_IDLE:  if (start_i) state_d = phase_i ? CW_OPEN : CW_ARMED;
      CW_ARMED: if (phase_i) state_d = CW_OPEN;
      CW_OPEN:  if (cut_tick_i && (pend_q || clear_i)) state_d = CW_IDLE;
      default:  state_d = CW_IDLE;
    endcase
    pend_d = (state_d == CW_OPEN) &&
             (pend_q || ((state_q == CW_OPEN) && clear_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CW_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign cut_o    = (state_q == CW_OPEN);
  assign run_o    = cut_o;
  assign active_o = (state_q != CW_IDLE);

  // R4
  rise_on_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cut_o) |-> $past(phase_i));

  // R6
  fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cut_o) |-> $past(cut_tick_i));

  // R5
  tick_only_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_tick_i |-> cut_o);

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && start_i && !cut_tick_i) |=> active_o);

endmodule

// File: rtl/cutout_window_timer.sv
module cutout_window_timer
  import cw_pkg::*;
#(
  parameter int CLK_HZ    = 16_000_000,
  parameter int BASE_US   = 58,
  parameter int OFFSET_US = 28,
  parameter int CUT_US    = 436
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic clear_req_i,
  output logic base_tick_o,
  output logic cutout_o,
  output logic window_o
);

  localparam int BASE_CYC = us_to_cyc(CLK_HZ, BASE_US);
  localparam int OFF_CYC  = us_to_cyc(CLK_HZ, OFFSET_US);
  localparam int CUT_CYC  = us_to_cyc(CLK_HZ, CUT_US);
  // Decision is taken one cycle before the output flop rises.
  localparam int MATCH_AT = OFF_CYC - 2;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       phase_hit;
  logic       cut_tick;
  logic       cut_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cw_base_tick #(
    .PERIOD   (BASE_CYC),
    .MATCH_AT (MATCH_AT)
  ) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_o  (base_tick_o),
    .match_o (phase_hit)
  );

  cw_window_timer #(
    .PERIOD (CUT_CYC)
  ) u_cut (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (cut_run),
    .tick_o (cut_tick)
  );

  cw_window_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_req_i),
    .clear_i    (clear_req_i),
    .phase_i    (phase_hit),
    .cut_tick_i (cut_tick),
    .run_o      (cut_run),
    .cut_o      (cutout_o),
    .active_o   (window_o)
  );

endmodule

// File: tb/cutout_window_timer_test.sv
module cutout_window_timer_test;

  localparam int CLK_HZ = 1_000_000;
  localparam int BASE   = 58;
  localparam int OFF    = 28;
  localparam int CUT    = 436;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_req, clear_req;
  logic tick, cut, win;

  cutout_window_timer #(
    .CLK_HZ    (CLK_HZ),
    .BASE_US   (58),
    .OFFSET_US (28),
    .CUT_US    (436)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_req_i (start_req),
    .clear_req_i (clear_req),
    .base_tick_o (tick),
    .cutout_o    (cut),
    .window_o    (win)
  );

  int n = 0;
  int last_tick = -1;
  int prev_tick = -1;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, n, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
    if (tick === 1'b1) begin
      if (prev_tick >= 0) check("R1", "tick spacing", n - prev_tick, BASE);
      prev_tick = n;
      last_tick = n;
    end
  endtask

  task automatic run_window(input int p, input int d);
    int s, r, c, f;
    while (last_tick < 0) step();
    while ((n - last_tick) != p) step();
    s = n;
    r = last_tick + OFF;
    while (r <= s) r += BASE;
    c = r + d;
    f = r + CUT;
    while (f <= c) f += CUT;
    check("R3", "cutout idle", int'(cut), 0);
    check("R3", "window idle", int'(win), 0);
    start_req = 1'b1;
    clear_req = 1'b1;   // R8: clear while idle is ignored
    step();
    start_req = 1'b0;
    clear_req = 1'b0;
    while (n < f + 2) begin
      if (n < r)       check("R3/R8", "cutout armed", int'(cut), 0);
      else if (n == r) check("R4", "cutout rise", int'(cut), 1);
      else if (n < f)  check("R5/R7", "cutout held", int'(cut), 1);
      else if (n == f) check("R6", "cutout fall", int'(cut), 0);
      else             check("R6", "cutout after", int'(cut), 0);
      if (n < f) check("R3", "window open", int'(win), 1);
      else       check("R6", "window closed", int'(win), 0);
      if (n == s + 1 && r > s + 1) begin
        clear_req = 1'b1;   // R8 clear while armed
        start_req = 1'b1;   // R7 start while armed
      end
      if (n == r + 3) start_req = 1'b1;  // R7 start while open
      if (n == c) clear_req = 1'b1;
      step();
      start_req = 1'b0;
      clear_req = 1'b0;
    end
  endtask

  initial begin
    int d;
    rst_n = 1'b0;
    start_req = 1'b1;
    clear_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R2", "tick in reset", int'(tick), 0);
      check("R2", "cutout in reset", int'(cut), 0);
      check("R2", "window in reset", int'(win), 0);
    end
    start_req = 1'b0;
    #2 rst_n = 1'b1;

    for (int p = 0; p < BASE; p++) begin
      if (p == 0)      d = 0;
      else if (p == 1) d = CUT - 1;
      else if (p == 2) d = CUT;
      else             d = (p * 37) % (2 * CUT);
      run_window(p, d);
    end

    // R2: asynchronous reset in the middle of an open window
    start_req = 1'b1;
    step();
    start_req = 1'b0;
    for (int i = 0; i < 2 * BASE && cut !== 1'b1; i++) step();
    check("R4", "window opened before reset", int'(cut), 1);
    #2 rst_n = 1'b0;
    #1;
    check("R2", "cutout on async reset", int'(cut), 0);
    check("R2", "window on async reset", int'(win), 0);
    step();
    #2 rst_n = 1'b1;
    prev_tick = -1;
    last_tick = -1;
    for (int i = 0; i < 3 * BASE; i++) step();
    run_window(5, 100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog expired at cycle %0d: actual 0 expected 1", n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule